// File: doc/BRIEF.md
# Branch Opcode Classifier

This block sorts a recorded control-flow transfer into one kind, for a branch-trace filter. Each request carries the first two opcode bytes and the ModRM byte of the instruction at the branch source, the source and target addresses, and a flag saying the instruction bytes could not be obtained. The block returns a 12-bit mask with at most one kind bit set. When the kind is known, one target-privilege bit is added to it. A mask of all zeros means the transfer could not be classified.

Privilege is not an input. Any address at or above the parameter `KERNEL_BASE` counts as kernel space, and any address below it counts as user space. A move from user space into kernel space is reported as a hardware interrupt, trap or fault, because such an event can occur on any instruction. System calls and software interrupts are the exceptions, since they enter the kernel on purpose. The result is registered and appears one cycle after the request is accepted.

Top module: `br_classifier`

## Requirements
- R1: During reset and in the first cycle after it, `res_valid_o` is 0 and `res_kind_o` is 0.
- R2: `res_valid_o` equals `req_valid_i` delayed by one clock. `res_kind_o` takes the result of a request on the edge that accepts the request, and keeps its value while `req_valid_i` is low.
- R3: The kind bits are: 2 call, 3 return, 4 system call, 5 system return, 6 software interrupt, 7 interrupt return, 8 conditional, 9 jump, 10 hardware interrupt/trap/fault, 11 indirect call. At most one of bits 11..2 is ever set.
- R4: One-byte opcodes map as follows. 0x70..0x7F and 0xE0..0xE3 give conditional. 0xC2, 0xC3, 0xCA and 0xCB give return. 0xCF gives interrupt return. 0xCC..0xCE give software interrupt. 0xE8 and 0x9A give call. 0xE9..0xEB give jump.
- R5: After the escape byte 0x0F, the second byte decides the kind. 0x05 or 0x34 give system call. 0x07 or 0x35 give system return. 0x80..0x8F give conditional. Every other second byte gives 0.
- R6: For opcode 0xFF, the ModRM field [5:3] decides the kind. A value of 2 or 3 gives indirect call. A value of 4 or 5 gives jump. Any other value gives 0.
- R7: An opcode not listed in R4 to R6 gives 0, unless R9 applies.
- R8: A non-zero result also carries the target privilege. Bit 0 is set for a user target and bit 1 for a kernel target, where kernel means the address is at or above `KERNEL_BASE`. A zero result carries neither bit.
- R9: If the source is user and the target is kernel, the kind becomes hardware interrupt/trap/fault (0x402 with the privilege bit). This applies to unknown opcodes too. System call and software interrupt keep their own kind.
- R10: A source or target address of 0 gives the result 0, and R9 does not apply.
- R11: A request with `undecodable_i` set gives the result 0, and R9 does not apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| opc0_i | input | 8 | First opcode byte |
| opc1_i | input | 8 | Second opcode byte (used after 0x0F) |
| modrm_i | input | 8 | ModRM byte (used for 0xFF) |
| from_addr_i | input | AW | Branch source address |
| to_addr_i | input | AW | Branch target address |
| undecodable_i | input | 1 | Instruction bytes unavailable |
| res_valid_o | output | 1 | Result present |
| res_kind_o | output | 12 | Kind mask plus privilege bit |

## Verification
The assertions assume the input fields are only meaningful in cycles where `req_valid_i` is high. The hold check assumes that nothing other than an accepted request may change the result register. The stimulus drives every field together on the falling edge and holds it for exactly one rising edge. Some sequences send back-to-back requests and others leave idle gaps, so both the hold rule and the one-cycle latency are exercised. Addresses come from a small set of values: zero, a user value, a kernel value, and the two values on either side of `KERNEL_BASE`. With this set the privilege assertions see every source/target combination.

// File: rtl/br_cls_pkg.sv
package br_cls_pkg;
  localparam int unsigned KIND_W = 12;

  localparam int unsigned B_USER  = 0;
  localparam int unsigned B_KERN  = 1;
  localparam int unsigned B_CALL  = 2;
  localparam int unsigned B_RET   = 3;
  localparam int unsigned B_SYSC  = 4;
  localparam int unsigned B_SYSR  = 5;
  localparam int unsigned B_SWI   = 6;
  localparam int unsigned B_IRET  = 7;
  localparam int unsigned B_COND  = 8;
  localparam int unsigned B_JMP   = 9;
  localparam int unsigned B_IRQ   = 10;
  localparam int unsigned B_ICALL = 11;

  typedef logic [KIND_W-1:0] kind_t;

  function automatic kind_t kbit(input int unsigned b);
    kind_t k;
    k    = '0;
    k[b] = 1'b1;
    return k;
  endfunction
endpackage

// File: rtl/br_priv_cmp.sv
module br_priv_cmp #(
  parameter int unsigned     AW    = 48,
  parameter logic [AW-1:0]   KBASE = {1'b1, {(AW-1){1'b0}}}
) (
  input  logic [AW-1:0] addr_i,
  output logic          kern_o,
  output logic          zero_o
);
  assign kern_o = (addr_i >= KBASE);
  assign zero_o = (addr_i == '0);
endmodule

// File: rtl/br_op_decode.sv
module br_op_decode
  import br_cls_pkg::*;
(
  input  logic [7:0] opc0_i,
  input  logic [7:0] opc1_i,
  input  logic [7:0] modrm_i,
  output kind_t      kind_o
);
  logic [2:0] reg_f;
  kind_t      esc_kind;
  kind_t      grp_kind;

  assign reg_f = modrm_i[5:3];

  // two-byte map after 0x0F
  always_comb begin
    case (opc1_i) inside
      8'h05, 8'h34:   esc_kind = kbit(B_SYSC);
      8'h07, 8'h35:   esc_kind = kbit(B_SYSR);
      [8'h80:8'h8F]:  esc_kind = kbit(B_COND);
      default:        esc_kind = '0;
    endcase
  end

  // 0xFF group selected by ModRM reg field
  always_comb begin
    case (reg_f)
      3'd2, 3'd3: grp_kind = kbit(B_ICALL);
      3'd4, 3'd5: grp_kind = kbit(B_JMP);
      default:    grp_kind = '0;
    endcase
  end

  always_comb begin
    case (opc0_i) inside
      8'h0F:                        kind_o = esc_kind;
      8'hFF:                        kind_o = grp_kind;
      [8'h70:8'h7F], [8'hE0:8'hE3]: kind_o = kbit(B_COND);
      8'hC2, 8'hC3, 8'hCA, 8'hCB:   kind_o = kbit(B_RET);
      8'hCF:                        kind_o = kbit(B_IRET);
      [8'hCC:8'hCE]:                kind_o = kbit(B_SWI);
      8'hE8, 8'h9A:                 kind_o = kbit(B_CALL);
      [8'hE9:8'hEB]:                kind_o = kbit(B_JMP);
      default:                      kind_o = '0;
    endcase
  end
endmodule

// File: rtl/br_kind_merge.sv
module br_kind_merge
  import br_cls_pkg::*;
(
  input  kind_t base_i,
  input  logic  from_kern_i,
  input  logic  to_kern_i,
  input  logic  force_none_i,
  output kind_t kind_o
);
  logic  ring_in;
  logic  exempt;
  kind_t k_ring;
  kind_t priv_bit;

  assign ring_in  = !from_kern_i && to_kern_i;
  assign exempt   = base_i[B_SYSC] | base_i[B_SWI];
  // asynchronous entry to kernel overrides even an unknown opcode
  assign k_ring   = (ring_in && !exempt) ? kbit(B_IRQ) : base_i;
  assign priv_bit = to_kern_i ? kbit(B_KERN) : kbit(B_USER);

  always_comb begin
    if (force_none_i || (k_ring == '0)) kind_o = '0;
    else                                kind_o = k_ring | priv_bit;
  end
endmodule

// File: rtl/br_classifier.sv
module br_classifier
  import br_cls_pkg::*;
#(
  parameter int unsigned   AW          = 48,
  parameter logic [AW-1:0] KERNEL_BASE = {1'b1, {(AW-1){1'b0}}}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [7:0]        opc0_i,
  input  logic [7:0]        opc1_i,
  input  logic [7:0]        modrm_i,
  input  logic [AW-1:0]     from_addr_i,
  input  logic [AW-1:0]     to_addr_i,
  input  logic              undecodable_i,
  output logic              res_valid_o,
  output logic [KIND_W-1:0] res_kind_o
);
  localparam int unsigned N_ADDR = 2;

  logic [AW-1:0] addr_w [N_ADDR];
  logic          kern_w [N_ADDR];
  logic          zero_w [N_ADDR];
  kind_t         base_kind;
  kind_t         next_kind;
  logic          force_none;

  assign addr_w[0] = from_addr_i;
  assign addr_w[1] = to_addr_i;

  for (genvar g = 0; g < N_ADDR; g++) begin : g_priv
    br_priv_cmp #(.AW(AW), .KBASE(KERNEL_BASE)) u_cmp (
      .addr_i (addr_w[g]),
      .kern_o (kern_w[g]),
      .zero_o (zero_w[g])
    );
  end

  br_op_decode u_dec (
    .opc0_i  (opc0_i),
    .opc1_i  (opc1_i),
    .modrm_i (modrm_i),
    .kind_o  (base_kind)
  );

  assign force_none = undecodable_i | zero_w[0] | zero_w[1];

  br_kind_merge u_merge (
    .base_i       (base_kind),
    .from_kern_i  (kern_w[0]),
    .to_kern_i    (kern_w[1]),
    .force_none_i (force_none),
    .kind_o       (next_kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_kind_o  <= '0;
    end else begin
      res_valid_o <= req_valid_i;
      if (req_valid_i) res_kind_o <= next_kind;
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!res_valid_o && $stable(res_kind_o))); // R2
  AST_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(res_kind_o[KIND_W-1:2])); // R3
  AST_PRIV_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_kind_o != '0) |-> ($countones(res_kind_o[1:0]) == 1 && res_kind_o[KIND_W-1:2] != '0)); // R8
  AST_RING_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !undecodable_i && from_addr_i != '0 && to_addr_i != '0 &&
     from_addr_i < KERNEL_BASE && to_addr_i >= KERNEL_BASE)
    |=> (res_kind_o[B_KERN] && (res_kind_o[B_IRQ] || res_kind_o[B_SYSC] || res_kind_o[B_SWI]))); // R9
  AST_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (from_addr_i == '0 || to_addr_i == '0)) |=> (res_kind_o == '0)); // R10
  AST_UNDECODABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && undecodable_i) |=> (res_kind_o == '0)); // R11
endmodule

// File: tb/br_classifier_tb_top.sv
`timescale 1ns/1ps
module br_classifier_tb_top;
  localparam int unsigned   AW = 48;
  localparam logic [AW-1:0] KB = 48'h8000_0000_0000;
  localparam logic [AW-1:0] UA = 48'h0000_0040_1000;
  localparam logic [AW-1:0] KA = 48'hFFFF_8100_2000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [7:0]    opc0_i = '0, opc1_i = '0, modrm_i = '0;
  logic [AW-1:0] from_addr_i = '0, to_addr_i = '0;
  logic          undecodable_i = 1'b0;
  logic          res_valid_o;
  logic [11:0]   res_kind_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  br_classifier #(.AW(AW), .KERNEL_BASE(KB)) dut_i (.*);

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %03h expected %03h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [7:0] o0, input logic [7:0] o1, input logic [7:0] mr,
                       input logic [AW-1:0] fa, input logic [AW-1:0] ta, input logic ud);
    @(negedge clk_i);
    req_valid_i = 1'b1; opc0_i = o0; opc1_i = o1; modrm_i = mr;
    from_addr_i = fa; to_addr_i = ta; undecodable_i = ud;
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_valid_i = 1'b0; opc0_i = 8'h00; from_addr_i = '0; to_addr_i = '0;
  endtask

  task automatic one(input string req, input logic [7:0] o0, input logic [7:0] o1,
                     input logic [7:0] mr, input logic [AW-1:0] fa, input logic [AW-1:0] ta,
                     input logic ud, input logic [11:0] exp);
    drive(o0, o1, mr, fa, ta, ud);
    @(posedge clk_i); #1;
    check({req, " valid"}, {11'd0, res_valid_o}, 12'h001);
    check(req, res_kind_o, exp);
    idle();
  endtask

  task automatic t_reset();
    #1;
    check("R1 valid in reset", {11'd0, res_valid_o}, 12'h000);
    check("R1 kind in reset", res_kind_o, 12'h000);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1 valid after reset", {11'd0, res_valid_o}, 12'h000);
    check("R1 kind after reset", res_kind_o, 12'h000);
  endtask

  task automatic t_one_byte();
    one("R4 jcc 74",  8'h74, 8'h00, 8'h00, UA, UA, 1'b0, 12'h101);
    one("R4 jcc 7F",  8'h7F, 8'h00, 8'h00, UA, UA, 1'b0, 12'h101);
    one("R4 loop E3", 8'hE3, 8'h00, 8'h00, UA, UA, 1'b0, 12'h101);
    one("R4 ret C3",  8'hC3, 8'h00, 8'h00, KA, KA, 1'b0, 12'h00A);
    one("R4 ret C2",  8'hC2, 8'h00, 8'h00, UA, UA, 1'b0, 12'h009);
    one("R4 ret CA",  8'hCA, 8'h00, 8'h00, UA, UA, 1'b0, 12'h009);
    one("R4 iret CF", 8'hCF, 8'h00, 8'h00, KA, UA, 1'b0, 12'h081);
    one("R4 int CD",  8'hCD, 8'h00, 8'h00, UA, UA, 1'b0, 12'h041);
    one("R4 call E8", 8'hE8, 8'h00, 8'h00, UA, UA, 1'b0, 12'h005);
    one("R4 call 9A", 8'h9A, 8'h00, 8'h00, KA, KA, 1'b0, 12'h006);
    one("R4 jmp E9",  8'hE9, 8'h00, 8'h00, UA, UA, 1'b0, 12'h201);
    one("R4 jmp EB",  8'hEB, 8'h00, 8'h00, UA, UA, 1'b0, 12'h201);
  endtask

  task automatic t_two_byte();
    one("R5 syscall 05 ring", 8'h0F, 8'h05, 8'h00, UA, KA, 1'b0, 12'h012);
    one("R5 syscall 34",      8'h0F, 8'h34, 8'h00, KA, KA, 1'b0, 12'h012);
    one("R5 sysret 07",       8'h0F, 8'h07, 8'h00, KA, UA, 1'b0, 12'h021);
    one("R5 sysret 35",       8'h0F, 8'h35, 8'h00, KA, UA, 1'b0, 12'h021);
    one("R5 jcc 0F80",        8'h0F, 8'h80, 8'h00, UA, UA, 1'b0, 12'h101);
    one("R5 jcc 0F8F",        8'h0F, 8'h8F, 8'h00, UA, UA, 1'b0, 12'h101);
    one("R5 other 0F90",      8'h0F, 8'h90, 8'h00, UA, UA, 1'b0, 12'h000);
    one("R5 other 0F06",      8'h0F, 8'h06, 8'h00, KA, KA, 1'b0, 12'h000);
  endtask

  task automatic t_group();
    one("R6 reg2 icall", 8'hFF, 8'h00, 8'h10, UA, UA, 1'b0, 12'h801);
    one("R6 reg3 icall", 8'hFF, 8'h00, 8'h1F, KA, KA, 1'b0, 12'h802);
    one("R6 reg2 mod3",  8'hFF, 8'h00, 8'hD0, UA, UA, 1'b0, 12'h801);
    one("R6 reg4 jmp",   8'hFF, 8'h00, 8'h20, UA, UA, 1'b0, 12'h201);
    one("R6 reg5 jmp",   8'hFF, 8'h00, 8'h28, UA, UA, 1'b0, 12'h201);
    one("R6 reg0",       8'hFF, 8'h00, 8'h00, UA, UA, 1'b0, 12'h000);
    one("R6 reg6",       8'hFF, 8'h00, 8'h30, UA, UA, 1'b0, 12'h000);
    one("R6 reg7",       8'hFF, 8'h00, 8'h38, KA, KA, 1'b0, 12'h000);
  endtask

  task automatic t_unknown();
    one("R7 nop user", 8'h90, 8'h00, 8'h00, UA, UA, 1'b0, 12'h000);
    one("R7 nop kern", 8'h90, 8'h00, 8'h00, KA, KA, 1'b0, 12'h000);
    one("R7 nop k->u", 8'h90, 8'h00, 8'h00, KA, UA, 1'b0, 12'h000);
  endtask

  task automatic t_priv_edge();
    one("R8 target at base",   8'hE9, 8'h00, 8'h00, KA, KB, 1'b0, 12'h202);
    one("R8 target below base", 8'hE9, 8'h00, 8'h00, KA, KB - 1, 1'b0, 12'h201);
    one("R8 source at base",   8'hC3, 8'h00, 8'h00, KB, KA, 1'b0, 12'h00A);
  endtask

  task automatic t_ring();
    one("R9 ret u->k irq",     8'hC3, 8'h00, 8'h00, UA, KA, 1'b0, 12'h402);
    one("R9 unknown u->k irq", 8'h90, 8'h00, 8'h00, UA, KA, 1'b0, 12'h402);
    one("R9 int u->k kept",    8'hCC, 8'h00, 8'h00, UA, KA, 1'b0, 12'h042);
    one("R9 below/at base",    8'h74, 8'h00, 8'h00, KB - 1, KB, 1'b0, 12'h402);
  endtask

  task automatic t_force_none();
    one("R10 from zero", 8'h74, 8'h00, 8'h00, '0, KA, 1'b0, 12'h000);
    one("R10 to zero",   8'hE8, 8'h00, 8'h00, UA, '0, 1'b0, 12'h000);
    one("R11 undecodable ring",  8'h90, 8'h00, 8'h00, UA, KA, 1'b1, 12'h000);
    one("R11 undecodable call",  8'hE8, 8'h00, 8'h00, UA, UA, 1'b1, 12'h000);
  endtask

  task automatic t_timing();
    one("R2 load", 8'hE8, 8'h00, 8'h00, UA, UA, 1'b0, 12'h005);
    // idle with new field values must not move the result
    @(negedge clk_i); opc0_i = 8'hC3; from_addr_i = KA; to_addr_i = KA;
    @(posedge clk_i); #1;
    check("R2 idle valid low", {11'd0, res_valid_o}, 12'h000);
    check("R2 idle hold", res_kind_o, 12'h005);
    // back-to-back requests
    drive(8'hCF, 8'h00, 8'h00, KA, UA, 1'b0);
    @(posedge clk_i); #1;
    check("R2 burst first", res_kind_o, 12'h081);
    drive(8'h0F, 8'h05, 8'h00, UA, KA, 1'b0);
    @(posedge clk_i); #1;
    check("R2 burst second", res_kind_o, 12'h012);
    check("R2 burst valid", {11'd0, res_valid_o}, 12'h001);
    idle();
    @(posedge clk_i); #1;
    check("R2 valid drops", {11'd0, res_valid_o}, 12'h000);
    check("R2 hold after burst", res_kind_o, 12'h012);
  endtask

  initial begin
    t_reset();
    t_one_byte();
    t_two_byte();
    t_group();
    t_unknown();
    t_priv_edge();
    t_ring();
    t_force_none();
    t_timing();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule